// File: doc/BRIEF.md
# Multi-Frame Mean and Deviation Pipeline

This block is the front end of a background model built from a small set of stored reference frames. On every clock it receives one word that carries the co-located pixel from each of eight reference frames. It forms the per-position mean of those pixels with a registered binary adder tree and a divide-by-eight. It then subtracts that mean from every one of the eight pixels, which gives eight zero-mean deviation values ready for the covariance stage that follows.

The raw pixels travel through a register delay line whose depth matches the adder tree. Each subtraction therefore uses the mean of its own pixel group, and a new group can enter on every cycle with no stalls. A valid flag moves through the pipeline with the data. Between results, the data outputs keep the last result that was delivered.

Top module: `pca_mean_dev`

## Requirements
- R1: While `rst_ni` is low, `valid_o` is 0, `mean_o` is 0 and every lane of `dev_o` is 0.
- R2: `mean_o` equals the sum of the eight input pixels, taken as unsigned values, divided by eight with the remainder discarded.
- R3: Each deviation lane is the signed 17-bit two's-complement value of its pixel minus `mean_o`. It covers the full range from -65535 to +65535 and never saturates, so that `mean_o` plus the lane always returns the original pixel.
- R4: A group presented with `valid_i` high at a rising clock edge appears with `valid_o` high exactly 4 rising edges later. `valid_o` follows `valid_i` delayed by those 4 edges on every cycle.
- R5: Groups presented on consecutive cycles give results on consecutive cycles, and each result is computed only from its own group.
- R6: Frame k (k = 0..7) occupies `pix_i[16k+15:16k]`, and its deviation appears on `dev_o[17k+16:17k]`.
- R7: When `valid_o` is low, `mean_o` and `dev_o` keep their previous values. Input words presented with `valid_i` low do not change them.
- R8: In every valid result, the signed sum of the eight deviation lanes lies between 0 and 7. It equals the remainder dropped by the division.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Marks `pix_i` as a pixel group to process |
| pix_i | input | 128 | Eight unsigned 16-bit pixels, frame k in bits 16k+15:16k |
| valid_o | output | 1 | Marks `mean_o` and `dev_o` as a new result |
| mean_o | output | 16 | Truncated mean of the group |
| dev_o | output | 136 | Eight signed 17-bit deviations, lane k in bits 17k+16:17k |

## Verification
A group of evenly spaced pixels checks the plain mean. Groups whose sums are not multiples of eight show whether the division truncates or rounds. A group with a single non-zero frame shows whether lanes are swapped or misplaced. All-maximum and one-maximum or one-zero groups drive the deviations to their extremes, which exposes any narrowed or saturated subtractor. A back-to-back burst where every group differs shows a delay line that is one stage short or long, and a lone pulse followed by idle cycles with junk data pins the latency and the hold behaviour.

// File: rtl/pca_mean_pkg.sv
package pca_mean_pkg;
  localparam int unsigned FRAMES_DEF = 8;
  localparam int unsigned PIX_W_DEF  = 16;

  function automatic int unsigned tree_levels(int unsigned frames);
    return $clog2(frames);
  endfunction

  function automatic int unsigned sum_width(int unsigned pix_w, int unsigned frames);
    return pix_w + $clog2(frames);
  endfunction
endpackage

// File: rtl/pca_adder_tree.sv
module pca_adder_tree #(
  parameter int unsigned FRAMES = 8,
  parameter int unsigned PIX_W  = 16,
  parameter int unsigned LVLS   = 3,
  parameter int unsigned SUM_W  = 19
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic [FRAMES*PIX_W-1:0] pix_i,
  output logic                    valid_o,
  output logic [SUM_W-1:0]        sum_o
);
  for (genvar l = 0; l <= LVLS; l++) begin : g_lvl
    localparam int unsigned CNT = FRAMES >> l;
    logic [SUM_W-1:0] node [CNT];
    logic             vld;

    if (l == 0) begin : g_leaf
      assign vld = valid_i;
      always_comb begin
        for (int i = 0; i < CNT; i++) node[i] = SUM_W'(pix_i[i*PIX_W +: PIX_W]);
      end
    end else begin : g_add
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          vld <= 1'b0;
          for (int i = 0; i < CNT; i++) node[i] <= '0;
        end else begin
          vld <= g_lvl[l-1].vld;
          if (g_lvl[l-1].vld) begin
            for (int i = 0; i < CNT; i++)
              node[i] <= g_lvl[l-1].node[2*i] + g_lvl[l-1].node[2*i+1];
          end
        end
      end
    end
  end

  assign sum_o   = g_lvl[LVLS].node[0];
  assign valid_o = g_lvl[LVLS].vld;
endmodule

// File: rtl/pca_pix_delay.sv
module pca_pix_delay #(
  parameter int unsigned WIDTH = 128,
  parameter int unsigned DEPTH = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [WIDTH-1:0] data_i,
  output logic             valid_o,
  output logic [WIDTH-1:0] data_o
);
  logic [DEPTH-1:0]            stg_v;
  logic [DEPTH-1:0][WIDTH-1:0] stg_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_v <= '0;
      stg_d <= '0;
    end else begin
      stg_v[0] <= valid_i;
      if (valid_i) stg_d[0] <= data_i;
      for (int k = 1; k < DEPTH; k++) begin
        stg_v[k] <= stg_v[k-1];
        if (stg_v[k-1]) stg_d[k] <= stg_d[k-1];
      end
    end
  end

  assign valid_o = stg_v[DEPTH-1];
  assign data_o  = stg_d[DEPTH-1];
endmodule

// File: rtl/pca_dev_sub.sv
module pca_dev_sub #(
  parameter int unsigned FRAMES = 8,
  parameter int unsigned PIX_W  = 16,
  parameter int unsigned SUM_W  = 19,
  parameter int unsigned DEV_W  = 17
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic [SUM_W-1:0]        sum_i,
  input  logic [FRAMES*PIX_W-1:0] pix_i,
  output logic                    valid_o,
  output logic [PIX_W-1:0]        mean_o,
  output logic [FRAMES*DEV_W-1:0] dev_o
);
  localparam int unsigned SHIFT = SUM_W - PIX_W;

  logic [PIX_W-1:0]        mean_nx;
  logic [FRAMES*DEV_W-1:0] dev_nx;

  // truncating divide by FRAMES
  assign mean_nx = PIX_W'(sum_i >> SHIFT);

  for (genvar k = 0; k < FRAMES; k++) begin : g_lane
    assign dev_nx[k*DEV_W +: DEV_W] =
      DEV_W'(pix_i[k*PIX_W +: PIX_W]) - DEV_W'(mean_nx);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      mean_o  <= '0;
      dev_o   <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        mean_o <= mean_nx;
        dev_o  <= dev_nx;
      end
    end
  end
endmodule

// File: rtl/pca_mean_dev.sv
module pca_mean_dev #(
  parameter int unsigned FRAMES = pca_mean_pkg::FRAMES_DEF,
  parameter int unsigned PIX_W  = pca_mean_pkg::PIX_W_DEF
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        valid_i,
  input  logic [FRAMES*PIX_W-1:0]     pix_i,
  output logic                        valid_o,
  output logic [PIX_W-1:0]            mean_o,
  output logic [FRAMES*(PIX_W+1)-1:0] dev_o
);
  localparam int unsigned LVLS  = pca_mean_pkg::tree_levels(FRAMES);
  localparam int unsigned SUM_W = pca_mean_pkg::sum_width(PIX_W, FRAMES);
  localparam int unsigned DEV_W = PIX_W + 1;
  localparam int unsigned BUS_W = FRAMES * PIX_W;

  logic             sum_vld;
  logic [SUM_W-1:0] sum;
  logic             dly_vld;
  logic [BUS_W-1:0] pix_dly;

  pca_adder_tree #(
    .FRAMES(FRAMES), .PIX_W(PIX_W), .LVLS(LVLS), .SUM_W(SUM_W)
  ) u_tree (
    .clk_i, .rst_ni, .valid_i, .pix_i,
    .valid_o(sum_vld), .sum_o(sum)
  );

  pca_pix_delay #(
    .WIDTH(BUS_W), .DEPTH(LVLS)
  ) u_dly (
    .clk_i, .rst_ni, .valid_i, .data_i(pix_i),
    .valid_o(dly_vld), .data_o(pix_dly)
  );

  pca_dev_sub #(
    .FRAMES(FRAMES), .PIX_W(PIX_W), .SUM_W(SUM_W), .DEV_W(DEV_W)
  ) u_sub (
    .clk_i, .rst_ni,
    .valid_i(sum_vld & dly_vld),
    .sum_i(sum), .pix_i(pix_dly),
    .valid_o, .mean_o, .dev_o
  );
endmodule

// File: rtl/pca_mean_dev_chk.sv
module pca_mean_dev_chk #(
  parameter int unsigned FRAMES = 8,
  parameter int unsigned PIX_W  = 16
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        valid_i,
  input logic                        valid_o,
  input logic [PIX_W-1:0]            mean_o,
  input logic [FRAMES*(PIX_W+1)-1:0] dev_o
);
  localparam int unsigned DEV_W = PIX_W + 1;
  localparam int unsigned LAT   = $clog2(FRAMES) + 1;
  localparam int unsigned ACC_W = DEV_W + $clog2(FRAMES) + 1;

  logic [LAT-1:0] vhist;
  logic [3:0]     since_rst;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vhist     <= '0;
      since_rst <= '0;
    end else begin
      vhist <= {vhist[LAT-2:0], valid_i};
      if (since_rst != 4'hf) since_rst <= since_rst + 4'd1;
    end
  end

  logic signed [ACC_W-1:0] dev_sum;
  logic                    recon_ok;
  always_comb begin
    dev_sum  = '0;
    recon_ok = 1'b1;
    for (int k = 0; k < FRAMES; k++) begin
      logic signed [ACC_W-1:0] d;
      logic signed [ACC_W-1:0] r;
      d = ACC_W'($signed(dev_o[k*DEV_W +: DEV_W]));
      r = d + ACC_W'($signed({1'b0, mean_o}));
      dev_sum = dev_sum + d;
      if (r < 0 || r > ACC_W'((1 << PIX_W) - 1)) recon_ok = 1'b0;
    end
  end

  assert_reset_idle_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (!valid_o && mean_o == '0 && dev_o == '0));

  assert_latency_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst >= 4'(LAT)) |-> (valid_o == vhist[LAT-1]));

  assert_recon_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> recon_ok);

  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> ($stable(mean_o) && $stable(dev_o)));

  assert_dev_sum_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (dev_sum >= 0 && dev_sum < ACC_W'(FRAMES)));
endmodule

bind pca_mean_dev pca_mean_dev_chk #(.FRAMES(FRAMES), .PIX_W(PIX_W)) u_chk (.*);

// File: tb/pca_mean_dev_bench.sv
module pca_mean_dev_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NF = 8;
  localparam int PW = 16;
  localparam int DW = 17;

  logic                 clk_i = 1'b0;
  logic                 rst_ni;
  logic                 valid_i;
  logic [NF*PW-1:0]     pix_i;
  logic                 valid_o;
  logic [PW-1:0]        mean_o;
  logic [NF*DW-1:0]     dev_o;

  pca_mean_dev u_pca_mean_dev (.clk_i, .rst_ni, .valid_i, .pix_i, .valid_o, .mean_o, .dev_o);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  bit           hist_v [0:1023];
  logic [127:0] hist_p [0:1023];
  int           cyc;
  int           exp_mean;
  int           exp_dev [NF];

  task automatic chk(bit ok, string tag, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic int lane_dev(int k);
    logic signed [DW-1:0] d;
    d = dev_o[k*DW +: DW];
    return int'(d);
  endfunction

  task automatic model(logic [127:0] p);
    int s = 0;
    for (int k = 0; k < NF; k++) s += int'(p[k*PW +: PW]);
    exp_mean = s / NF;
    for (int k = 0; k < NF; k++) exp_dev[k] = int'(p[k*PW +: PW]) - exp_mean;
  endtask

  // check outputs due now, then drive the next input
  task automatic step(string tag, bit v, logic [127:0] p);
    bit ev;
    @(negedge clk_i);
    ev = (cyc >= 4) ? hist_v[cyc-4] : 1'b0;
    chk(valid_o == ev, {tag, " R4 valid"}, int'(valid_o), int'(ev));
    if (ev) model(hist_p[cyc-4]);
    chk(int'(mean_o) == exp_mean, {tag, " mean"}, int'(mean_o), exp_mean);
    for (int k = 0; k < NF; k++)
      chk(lane_dev(k) == exp_dev[k], {tag, " dev lane"}, lane_dev(k), exp_dev[k]);
    if (ev) begin
      int s = 0;
      for (int k = 0; k < NF; k++) s += lane_dev(k);
      chk(s >= 0 && s <= 7, "R8 deviation sum", s, 0);
    end
    valid_i = v;
    pix_i   = p;
    hist_v[cyc] = v;
    hist_p[cyc] = p;
    cyc++;
  endtask

  task automatic flush(string tag, int n);
    for (int i = 0; i < n; i++) step(tag, 1'b0, 128'hdead_beef_0bad_f00d_1234_5678_9abc_def0);
  endtask

  task automatic t_reset();
    rst_ni  = 1'b0;
    valid_i = 1'b1;
    pix_i   = '1;
    repeat (3) @(negedge clk_i);
    chk(valid_o == 1'b0, "R1 valid in reset", int'(valid_o), 0);
    chk(mean_o == '0, "R1 mean in reset", int'(mean_o), 0);
    chk(dev_o == '0, "R1 dev in reset", int'(dev_o[31:0]), 0);
    valid_i = 1'b0;
    pix_i   = '0;
    cyc = 0;
    exp_mean = 0;
    for (int k = 0; k < NF; k++) exp_dev[k] = 0;
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic t_basic();
    step("R2 basic", 1'b1, {16'd80, 16'd70, 16'd60, 16'd50, 16'd40, 16'd30, 16'd20, 16'd10});
    flush("R2 basic", 5);
  endtask

  task automatic t_trunc();
    step("R2 trunc one", 1'b1, {112'd0, 16'd1});
    step("R2 trunc 63", 1'b1, {16'd14, 16'd7, 16'd7, 16'd7, 16'd7, 16'd7, 16'd7, 16'd7});
    step("R2 trunc 15", 1'b1, {16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 16'd8, 16'd7});
    flush("R2 trunc", 5);
  endtask

  task automatic t_lane();
    step("R6 lane5", 1'b1, {16'd0, 16'd0, 16'd800, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0});
    step("R6 lane0", 1'b1, {16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 16'd1600});
    flush("R6 lane", 5);
  endtask

  task automatic t_extreme();
    step("R3 all max", 1'b1, '1);
    step("R3 one max", 1'b1, {112'd0, 16'hffff});
    step("R3 one zero", 1'b1, {{7{16'hffff}}, 16'h0000});
    flush("R3 extreme", 5);
  endtask

  task automatic t_latency();
    step("R4 pulse", 1'b1, {16'd9, 16'd9, 16'd9, 16'd9, 16'd9, 16'd9, 16'd9, 16'd9});
    flush("R4 pulse", 7);
  endtask

  task automatic t_burst();
    for (int j = 0; j < 12; j++) begin
      logic [127:0] p;
      for (int k = 0; k < NF; k++) p[k*PW +: PW] = 16'((j * 4099 + k * 773 + j * k * 311) & 16'hffff);
      step("R5 burst", 1'b1, p);
    end
    flush("R5 burst", 5);
  endtask

  task automatic t_hold();
    step("R7 hold", 1'b1, {16'd5, 16'd100, 16'd200, 16'd3, 16'd4000, 16'd1, 16'd2, 16'd9});
    step("R7 hold", 1'b0, '1);
    step("R7 hold", 1'b0, 128'h1111_2222_3333_4444_5555_6666_7777_8888);
    step("R7 hold", 1'b1, {16'd1000, 112'd0});
    step("R7 hold", 1'b0, '1);
    flush("R7 hold", 8);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_trunc();
    t_lane();
    t_extreme();
    t_latency();
    t_burst();
    t_hold();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule